// File: doc/BRIEF.md
# Coprocessor Mailbox Port Block

This block sits between a byte-wide coprocessor and a host processor and lets them pass single bytes to each other through a pair of one-byte registers. Each direction has its own "byte waiting" flag. The coprocessor reaches the block through I/O reads and writes. The port is chosen by the upper three bits of an 8-bit port address, and the lower five bits play no part. The host has its own data port. A host write deposits a byte for the coprocessor. A host read collects the byte the coprocessor left for it.

Two further coprocessor write ports hold memory-control settings, which the block exports as plain outputs. One is a ROM-overlay enable. The other carries a 3-bit bank number and a common-area enable.

Each flag is a two-state machine. The states are FLG_EMPTY and FLG_FULL, with two transitions: SET (FLG_EMPTY or FLG_FULL to FLG_FULL) and CLEAR (FLG_FULL to FLG_EMPTY). Each read strobe goes through a two-state tracker. Its states are RD_IDLE and RD_HELD, with two transitions: ARM (RD_IDLE to RD_HELD while the strobe is high) and RELEASE (RD_HELD to RD_IDLE when the strobe drops). A read side effect fires only on the ARM transition.

Top module: `copro_mbox`

## Requirements
- R1: The port group is `cp_addr[7:5]`. Bits [4:0] of the address never change which group is read or written.
- R2: A coprocessor write to group 0 (addresses 0x00–0x1F) loads the outbound byte and sets `hs_avail`. `hs_rdata` and a coprocessor read of group 0 both return the outbound byte.
- R3: A coprocessor read of group 1 (0x20–0x3F) returns the inbound byte, and its strobe clears `cp_avail`.
- R4: A coprocessor read of group 2 (0x40–0x5F) returns a status byte. Bit 7 equals `cp_avail`, bit 0 equals `hs_avail`, and bits 6:1 are 0.
- R5: Reads of groups 3, 4, 5, 6 and 7 return 0x00. Writes to groups 1, 2, 4, 5 and 7 change no register and no flag.
- R6: A write to group 3 (0x60–0x7F) loads `shadow_en` from data bit 0. A write to group 6 (0xC0–0xDF) loads `bank_sel` from data bits 3:1 and `common_en` from data bit 6.
- R7: After reset, both flags are 0, `shadow_en` is 1, `bank_sel` and `common_en` are 0, and the outbound and inbound bytes are 0x00.
- R8: A host write loads the inbound byte and sets `cp_avail`. A host read clears `hs_avail`.
- R9: When a flag receives a set and a clear in the same cycle, it ends up set.
- R10: A read strobe held high for several cycles clears its flag only once, in the first cycle. A set arriving while the strobe is still held stays in effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cp_addr | input | 8 | Coprocessor port address |
| cp_wdata | input | 8 | Coprocessor write data |
| cp_wr | input | 1 | Coprocessor single-cycle write strobe |
| cp_rd | input | 1 | Coprocessor read strobe |
| cp_rdata | output | 8 | Coprocessor read data, combinational from the address |
| hs_wdata | input | 8 | Host write data |
| hs_wr | input | 1 | Host single-cycle write strobe |
| hs_rd | input | 1 | Host read strobe |
| hs_rdata | output | 8 | Outbound byte for the host |
| hs_avail | output | 1 | Byte waiting for the host |
| cp_avail | output | 1 | Byte waiting for the coprocessor |
| shadow_en | output | 1 | ROM overlay enable |
| bank_sel | output | 3 | Memory bank number |
| common_en | output | 1 | Common-area enable |

## Verification
Two events can reach the same flag in one cycle. For `cp_avail`, a coprocessor read of group 1 (CLEAR) can coincide with a host write (SET). For `hs_avail`, a host read (CLEAR) can coincide with a coprocessor write to group 0 (SET). The bench drives both strobes on the same clock edge and expects the flag to be 1 afterwards, along with the newly written byte. It also holds a read strobe across a host write and expects the flag to stay set once the strobe is released.

// File: rtl/copro_mbox_pkg.sv
package copro_mbox_pkg;
    typedef enum logic [2:0] {
        GRP_OUTB   = 3'd0,
        GRP_INB    = 3'd1,
        GRP_STAT   = 3'd2,
        GRP_SHADOW = 3'd3,
        GRP_NONE4  = 3'd4,
        GRP_NONE5  = 3'd5,
        GRP_BANK   = 3'd6,
        GRP_NONE7  = 3'd7
    } port_grp_e;

    typedef enum logic {
        FLG_EMPTY = 1'b0,
        FLG_FULL  = 1'b1
    } flag_state_e;

    typedef enum logic {
        RD_IDLE = 1'b0,
        RD_HELD = 1'b1
    } rd_state_e;
endpackage

// File: rtl/copro_port_decode.sv
module copro_port_decode
    import copro_mbox_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int SEL_W  = 3
) (
    input  logic [ADDR_W-1:0] addr_i,
    output port_grp_e         grp_o
);
    localparam int SEL_MSB = ADDR_W - 1;

    always_comb begin
        grp_o = port_grp_e'(addr_i[SEL_MSB -: SEL_W]);
    end
endmodule

// File: rtl/copro_rd_edge.sv
module copro_rd_edge
    import copro_mbox_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_i,
    output logic pulse_o
);
    rd_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RD_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        pulse_o = 1'b0;
        unique case (state_q)
            RD_IDLE: begin
                if (rd_i) begin
                    state_d = RD_HELD;  // ARM
                    pulse_o = 1'b1;
                end
            end
            RD_HELD: begin
                if (!rd_i) state_d = RD_IDLE;  // RELEASE
            end
        endcase
    end

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> !pulse_o); // R10
    AST_HELD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && $past(rd_i) && $past(rst_n)) |-> !pulse_o); // R10
endmodule

// File: rtl/copro_hs_flag.sv
module copro_hs_flag
    import copro_mbox_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic full_o
);
    flag_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FLG_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_EMPTY: if (set_i) state_d = FLG_FULL;     // SET
            FLG_FULL:  if (!set_i && clr_i) state_d = FLG_EMPTY; // CLEAR
        endcase
    end

    always_comb begin
        full_o = (state_q == FLG_FULL);
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> full_o); // R9
    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !full_o); // R3
endmodule

// File: rtl/copro_mbox.sv
module copro_mbox
    import copro_mbox_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int SEL_W  = 3,
    parameter int BANK_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cp_addr,
    input  logic [DATA_W-1:0] cp_wdata,
    input  logic              cp_wr,
    input  logic              cp_rd,
    output logic [DATA_W-1:0] cp_rdata,
    input  logic [DATA_W-1:0] hs_wdata,
    input  logic              hs_wr,
    input  logic              hs_rd,
    output logic [DATA_W-1:0] hs_rdata,
    output logic              hs_avail,
    output logic              cp_avail,
    output logic              shadow_en,
    output logic [BANK_W-1:0] bank_sel,
    output logic              common_en
);
    localparam int STAT_CP_BIT = DATA_W - 1;
    localparam int STAT_HS_BIT = 0;
    localparam int BANK_LSB    = 1;
    localparam int COMMON_BIT  = 6;

    port_grp_e         grp;
    logic              cp_rd_pulse;
    logic              hs_rd_pulse;
    logic [DATA_W-1:0] outb_q;
    logic [DATA_W-1:0] inb_q;
    logic              wr_outb;
    logic              clr_cp;

    copro_port_decode #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_dec (
        .addr_i (cp_addr),
        .grp_o  (grp)
    );

    copro_rd_edge u_cp_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_i    (cp_rd),
        .pulse_o (cp_rd_pulse)
    );

    copro_rd_edge u_hs_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_i    (hs_rd),
        .pulse_o (hs_rd_pulse)
    );

    always_comb begin
        wr_outb = cp_wr && (grp == GRP_OUTB);
        clr_cp  = cp_rd_pulse && (grp == GRP_INB);
    end

    copro_hs_flag u_hs_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (wr_outb),
        .clr_i  (hs_rd_pulse),
        .full_o (hs_avail)
    );

    copro_hs_flag u_cp_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (hs_wr),
        .clr_i  (clr_cp),
        .full_o (cp_avail)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outb_q    <= '0;
            inb_q     <= '0;
            shadow_en <= 1'b1;
            bank_sel  <= '0;
            common_en <= 1'b0;
        end else begin
            if (hs_wr) inb_q <= hs_wdata;
            if (cp_wr) begin
                unique case (grp)
                    GRP_OUTB:   outb_q    <= cp_wdata;
                    GRP_SHADOW: shadow_en <= cp_wdata[0];
                    GRP_BANK: begin
                        bank_sel  <= cp_wdata[BANK_LSB +: BANK_W];
                        common_en <= cp_wdata[COMMON_BIT];
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        cp_rdata = '0;
        unique case (grp)
            GRP_OUTB: cp_rdata = outb_q;
            GRP_INB:  cp_rdata = inb_q;
            GRP_STAT: begin
                cp_rdata[STAT_CP_BIT] = cp_avail;
                cp_rdata[STAT_HS_BIT] = hs_avail;
            end
            default: cp_rdata = '0;
        endcase
    end

    always_comb begin
        hs_rdata = outb_q;
    end

    AST_OUTB_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_wr && cp_addr[ADDR_W-1 -: SEL_W] == 3'd0) |=> (hs_rdata == $past(cp_wdata))); // R2
    AST_SHADOW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_wr && cp_addr[ADDR_W-1 -: SEL_W] == 3'd3) |=> (shadow_en == $past(cp_wdata[0]))); // R6
    AST_STATUS_ZEROS: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_addr[ADDR_W-1 -: SEL_W] == 3'd2) |-> (cp_rdata[DATA_W-2:1] == '0)); // R4
    AST_HOST_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        hs_wr |=> (cp_avail && inb_q == $past(hs_wdata))); // R8
    AST_CTRL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cp_wr && $past(rst_n)) |=> ($stable(bank_sel) && $stable(common_en))); // R5
endmodule

// File: tb/copro_mbox_tb.sv
module copro_mbox_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cp_addr = '0, cp_wdata = '0, hs_wdata = '0;
    logic       cp_wr = 0, cp_rd = 0, hs_wr = 0, hs_rd = 0;
    logic [7:0] cp_rdata, hs_rdata;
    logic       hs_avail, cp_avail, shadow_en, common_en;
    logic [2:0] bank_sel;

    int errors = 0, checks = 0;
    bit done = 0;

    // bench model
    logic [7:0] m_outb = 0, m_inb = 0;
    logic       m_cpf = 0, m_hsf = 0, m_shadow = 1, m_common = 0;
    logic [2:0] m_bank = 0;

    always #4 clk = ~clk;  // 125 MHz

    copro_mbox u_dut (
        .clk(clk), .rst_n(rst_n), .cp_addr(cp_addr), .cp_wdata(cp_wdata),
        .cp_wr(cp_wr), .cp_rd(cp_rd), .cp_rdata(cp_rdata), .hs_wdata(hs_wdata),
        .hs_wr(hs_wr), .hs_rd(hs_rd), .hs_rdata(hs_rdata), .hs_avail(hs_avail),
        .cp_avail(cp_avail), .shadow_en(shadow_en), .bank_sel(bank_sel),
        .common_en(common_en)
    );

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(logic [7:0] a);
        case (a >> 5)
            0: return m_outb;
            1: return m_inb;
            2: return {m_cpf, 6'b0, m_hsf};
            default: return 8'h00;
        endcase
    endfunction

    task automatic check_state(string req);
        chk(req, hs_rdata, m_outb);
        chk(req, {7'b0, hs_avail}, {7'b0, m_hsf});
        chk(req, {7'b0, cp_avail}, {7'b0, m_cpf});
        chk(req, {7'b0, shadow_en}, {7'b0, m_shadow});
        chk(req, {5'b0, bank_sel}, {5'b0, m_bank});
        chk(req, {7'b0, common_en}, {7'b0, m_common});
    endtask

    task automatic cp_write(logic [7:0] a, logic [7:0] d);
        @(negedge clk); cp_addr = a; cp_wdata = d; cp_wr = 1;
        @(negedge clk); cp_wr = 0;
        case (a >> 5)
            0: begin m_outb = d; m_hsf = 1; end
            3: m_shadow = d[0];
            6: begin m_bank = d[3:1]; m_common = d[6]; end
            default: ;
        endcase
    endtask

    task automatic host_write(logic [7:0] d);
        @(negedge clk); hs_wdata = d; hs_wr = 1;
        @(negedge clk); hs_wr = 0;
        m_inb = d; m_cpf = 1;
    endtask

    task automatic cp_read(string req, logic [7:0] a);
        @(negedge clk); cp_addr = a; cp_rd = 1;
        #1 chk(req, cp_rdata, exp_read(a));
        @(negedge clk); cp_rd = 0;
        if ((a >> 5) == 1) m_cpf = 0;
        @(negedge clk);
    endtask

    task automatic host_read(string req);
        @(negedge clk); hs_rd = 1;
        #1 chk(req, hs_rdata, m_outb);
        @(negedge clk); hs_rd = 0;
        m_hsf = 0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R7 reset state
        check_state("R7");
        cp_addr = 8'h20; #1 chk("R7", cp_rdata, 8'h00);

        // R1 R3 R4 R5: read sweep over every address
        for (int a = 0; a < 256; a++) begin
            if (a % 16 == 0) host_write(8'(a ^ 8'h5A));
            if (a % 24 == 5) cp_write(8'(a % 32), 8'(a * 7));
            cp_read((a >> 5) == 1 ? "R3" : (a >> 5) == 2 ? "R4" : (a >> 5) == 0 ? "R2" : "R5_R1", 8'(a));
        end
        check_state("R3");

        // R1 R2 R5 R6: write sweep over every group with several data values
        for (int d = 0; d < 8; d++) begin
            for (int g = 0; g < 8; g++) begin
                logic [7:0] dv;
                dv = 8'((d * 37 + g * 11) ^ (d << 4));
                cp_write(8'((g << 5) | ((g * 3 + d) & 31)), dv);
                check_state(g == 3 || g == 6 ? "R6" : g == 0 ? "R2" : "R5_R1");
            end
            host_read("R8");
            check_state("R8");
        end

        // R8 host write then coprocessor read back
        host_write(8'hC3);
        check_state("R8");
        cp_read("R8", 8'h3F);
        check_state("R8");

        // R9 simultaneous clear and set on cp flag
        host_write(8'h11);
        @(negedge clk); cp_addr = 8'h20; cp_rd = 1; hs_wdata = 8'h99; hs_wr = 1;
        @(negedge clk); cp_rd = 0; hs_wr = 0; m_inb = 8'h99; m_cpf = 1;
        chk("R9", {7'b0, cp_avail}, 8'h01);
        @(negedge clk);
        // R9 simultaneous clear and set on host flag
        @(negedge clk); cp_addr = 8'h1F; cp_wdata = 8'h6E; cp_wr = 1; hs_rd = 1;
        @(negedge clk); cp_wr = 0; hs_rd = 0; m_outb = 8'h6E; m_hsf = 1;
        chk("R9", {7'b0, hs_avail}, 8'h01);
        check_state("R9");
        @(negedge clk);

        // R10 held read: one clear, later set survives
        @(negedge clk); cp_addr = 8'h25; cp_rd = 1;
        @(negedge clk); chk("R10", {7'b0, cp_avail}, 8'h00);
        hs_wdata = 8'h42; hs_wr = 1;
        @(negedge clk); hs_wr = 0;
        repeat (3) begin
            @(negedge clk); chk("R10", {7'b0, cp_avail}, 8'h01);
        end
        cp_rd = 0; m_inb = 8'h42; m_cpf = 1;
        @(negedge clk); chk("R10", {7'b0, cp_avail}, 8'h01);
        // R10 held host read
        @(negedge clk); hs_rd = 1;
        @(negedge clk); chk("R10", {7'b0, hs_avail}, 8'h00);
        cp_addr = 8'h00; cp_wdata = 8'hB7; cp_wr = 1;
        @(negedge clk); cp_wr = 0;
        repeat (2) begin
            @(negedge clk); chk("R10", {7'b0, hs_avail}, 8'h01);
        end
        hs_rd = 0; m_outb = 8'hB7; m_hsf = 1;
        @(negedge clk); check_state("R10");

        // R7 reset again after activity
        rst_n = 0; @(negedge clk); rst_n = 1;
        m_outb = 0; m_inb = 0; m_cpf = 0; m_hsf = 0; m_shadow = 1; m_bank = 0; m_common = 0;
        @(negedge clk); check_state("R7");
        cp_read("R7", 8'h20);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule